// File: doc/BRIEF.md
# Debug Run-Control Unit

This block decides, on behalf of an external debugger, whether a 16-bit processor core executes freely, stops, or advances by a single instruction. The debugger reaches it through a small register port: a control register carries one-shot commands (stop, resume, single step) and persistent configuration bits, and a status register reports whether the core is stopped and which break sources have fired since the debugger last acknowledged them.

Break requests come from four places: a dedicated breakpoint opcode seen on the fetch bus, per-unit hit strobes from external hardware breakpoint comparators, power-up-clear events when break-on-reset is configured, and the debugger's own stop command. Apart from a power-up-clear, a request only takes effect when the core reports an instruction boundary, so the core is never frozen in the middle of an instruction. The whole unit is held in its reset state while a debug-enable input, brought into the clock domain through a synchronizer, is low.

Top module: `dbgrc_top`

## Requirements
- R1: After `rst_n` is released, and again at most SYNC_STAGES+1 cycles after `dbg_enable` goes low, `cpu_halt`, `cpu_reset` and `dbg_freeze` are 0, the status register reads 0, and the control register reads only bit 5 equal to RSTBRK_DEFAULT (default 0).
- R2: Control register (`reg_sel`=0): bit 0 stop, bit 1 resume, bit 2 single step are write-one commands that read back 0; bit 3 breakpoint-opcode enable, bit 4 freeze enable, bit 5 break-on-reset, bit 6 core reset are stored and read back; bit 7 reads 0.
- R3: Status register (`reg_sel`=1): bit 0 is 1 while the core is stopped, bit 1 reset-occurred, bit 3 opcode breakpoint, bit 4+i hardware unit i; bits 2, 6, 7 read 0.
- R4: A stop command or break event while running asserts `cpu_halt` on the cycle after the first cycle (the request cycle included) in which `insn_boundary` is 1; without a boundary `cpu_halt` stays 0.
- R5: A resume command while stopped clears `cpu_halt` on the next cycle; when stop is written together with resume or step, the stop wins and the core stays stopped.
- R6: A step command while stopped clears `cpu_halt` on the next cycle and sets it again on the cycle after the next `insn_boundary`.
- R7: A fetch with `fetch_valid`=1 and `fetch_opcode`=16'h4343 while control bit 3 is 1 sets status bit 3 and requests a stop; with bit 3 clear, or with any other opcode, neither happens.
- R8: `hwbrk_hit[i]` sets status bit 4+i and requests a stop.
- R9: Status bits 1, 3, 4, 5 are sticky; writing 1 to a bit clears it, writing 0 leaves it, and a new event in the same cycle as the clearing write leaves it set.
- R10: `puc_event` always sets status bit 1; with control bit 5 set it also asserts `cpu_halt` on the next cycle with no boundary needed.
- R11: `cpu_reset` equals control bit 6; writing that bit from 0 to 1 sets status bit 1, rewriting it while already 1 does not.
- R12: `dbg_freeze` is 1 exactly while the core is stopped and control bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_enable | input | 1 | Asynchronous debug enable; low holds the unit in reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| fetch_valid | input | 1 | Fetch bus carries an opcode this cycle |
| fetch_opcode | input | 16 | Fetched opcode |
| hwbrk_hit | input | NUM_HWBRK | Hit strobes from hardware breakpoint units |
| puc_event | input | 1 | Power-up-clear occurred this cycle |
| insn_boundary | input | 1 | Core completes an instruction this cycle |
| cpu_halt | output | 1 | Stop the core |
| cpu_reset | output | 1 | Debugger-driven core reset |
| dbg_freeze | output | 1 | Freeze peripherals while stopped |

## Verification
Two things collide in one cycle by design: a pending flag being cleared by a status write while its source fires again, and a stop command arriving together with the instruction boundary it needs. The bench drives a hardware hit in the very cycle of the clearing write and expects the flag still set, and it writes the stop command with `insn_boundary` high so that `cpu_halt` must rise on the next cycle. A stop written together with resume and step while stopped is judged by `cpu_halt` staying high for two cycles.

// File: rtl/dbgrc_pkg.sv
package dbgrc_pkg;

  localparam int REG_W = 8;

  // control register bit positions
  localparam int CTL_HALT   = 0;
  localparam int CTL_RUN    = 1;
  localparam int CTL_STEP   = 2;
  localparam int CTL_SWBRK  = 3;
  localparam int CTL_FRZ    = 4;
  localparam int CTL_RSTBRK = 5;
  localparam int CTL_CPURST = 6;

  // status register bit positions
  localparam int ST_HALTED  = 0;
  localparam int ST_PUC     = 1;
  localparam int ST_SWBRK   = 3;
  localparam int ST_HW_BASE = 4;

  typedef enum logic [1:0] {
    RC_RUN    = 2'd0,
    RC_HALTED = 2'd1,
    RC_STEP   = 2'd2
  } rc_state_e;

  // bits of the control register that hold state
  function automatic logic [REG_W-1:0] ctl_store_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[CTL_SWBRK]  = 1'b1;
    m[CTL_FRZ]    = 1'b1;
    m[CTL_RSTBRK] = 1'b1;
    m[CTL_CPURST] = 1'b1;
    return m;
  endfunction

  // bits of the status register that are sticky pending flags
  function automatic logic [REG_W-1:0] pend_mask(input int nhw);
    logic [REG_W-1:0] m;
    m = '0;
    m[ST_PUC]   = 1'b1;
    m[ST_SWBRK] = 1'b1;
    for (int i = 0; i < nhw; i++) m[ST_HW_BASE+i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dbgrc_sync.sv
module dbgrc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dbgrc_opdet.sv
module dbgrc_opdet #(
  parameter int              OPC_W      = 16,
  parameter logic [OPC_W-1:0] BRK_OPCODE = 16'h4343
) (
  input  logic             fetch_valid,
  input  logic [OPC_W-1:0] fetch_opcode,
  input  logic             detect_en,
  output logic             hit
);
  assign hit = fetch_valid && detect_en && (fetch_opcode == BRK_OPCODE);
endmodule

// File: rtl/dbgrc_regs.sv
module dbgrc_regs
  import dbgrc_pkg::*;
#(
  parameter int   NUM_HWBRK      = 2,
  parameter logic RSTBRK_DEFAULT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 swbrk_hit,
  input  logic [NUM_HWBRK-1:0] hwbrk_hit,
  input  logic                 puc_event,
  input  logic                 halted,
  output logic                 cfg_swbrk_en,
  output logic                 cfg_frz_en,
  output logic                 cfg_rstbrk_en,
  output logic                 cfg_cpu_rst,
  output logic                 cmd_halt,
  output logic                 cmd_run,
  output logic                 cmd_step
);
  localparam logic [REG_W-1:0] CTL_MASK  = ctl_store_mask();
  localparam logic [REG_W-1:0] PND_MASK  = pend_mask(NUM_HWBRK);
  localparam logic [REG_W-1:0] CTL_RESET = REG_W'(RSTBRK_DEFAULT) << CTL_RSTBRK;

  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] pnd_q;
  logic             ctl_wr, st_wr;
  logic             rst_rise;
  logic [REG_W-1:0] pnd_set, pnd_clr;

  assign ctl_wr   = reg_wr && !reg_sel;
  assign st_wr    = reg_wr &&  reg_sel;
  assign cmd_halt = ctl_wr && reg_wdata[CTL_HALT];
  assign cmd_run  = ctl_wr && reg_wdata[CTL_RUN];
  assign cmd_step = ctl_wr && reg_wdata[CTL_STEP];
  assign rst_rise = ctl_wr && reg_wdata[CTL_CPURST] && !ctl_q[CTL_CPURST];

  always_comb begin
    pnd_set = '0;
    pnd_set[ST_PUC]   = puc_event || rst_rise;
    pnd_set[ST_SWBRK] = swbrk_hit;
    for (int i = 0; i < NUM_HWBRK; i++) pnd_set[ST_HW_BASE+i] = hwbrk_hit[i];
    pnd_clr = st_wr ? (reg_wdata & PND_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
      pnd_q <= '0;
    end else if (!en) begin
      ctl_q <= CTL_RESET;
      pnd_q <= '0;
    end else begin
      if (ctl_wr) ctl_q <= reg_wdata & CTL_MASK;
      pnd_q <= ((pnd_q & ~pnd_clr) | pnd_set) & PND_MASK;
    end
  end

  assign cfg_swbrk_en  = ctl_q[CTL_SWBRK];
  assign cfg_frz_en    = ctl_q[CTL_FRZ];
  assign cfg_rstbrk_en = ctl_q[CTL_RSTBRK];
  assign cfg_cpu_rst   = ctl_q[CTL_CPURST];

  always_comb begin
    if (reg_sel) begin
      reg_rdata            = pnd_q;
      reg_rdata[ST_HALTED] = halted;
    end else begin
      reg_rdata = ctl_q;
    end
  end

  // R9: a pending flag only drops after a write of 1 to it
  for (genvar b = 0; b < REG_W; b++) begin : g_pnd_chk
    if (PND_MASK[b]) begin : g_on
      a_r9_sticky_pending: assert property (@(posedge clk) disable iff (!rst_n || !en)
        ($fell(pnd_q[b]) && $past(en)) |-> $past(st_wr && reg_wdata[b]));
    end
  end

  // R11: the core reset bit holds while no control write occurs
  a_r11_reset_holds: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (cfg_cpu_rst && !ctl_wr) |=> cfg_cpu_rst);
endmodule

// File: rtl/dbgrc_seq.sv
module dbgrc_seq
  import dbgrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cmd_halt,
  input  logic cmd_run,
  input  logic cmd_step,
  input  logic brk_evt,
  input  logic puc_brk,
  input  logic insn_boundary,
  output logic halted
);
  rc_state_e st_q, st_nx;
  logic      pend_q, pend_nx;
  logic      want_stop;

  assign want_stop = pend_q || cmd_halt || brk_evt;

  always_comb begin
    st_nx   = st_q;
    pend_nx = pend_q;
    case (st_q)
      RC_RUN: begin
        if (puc_brk || (want_stop && insn_boundary)) begin
          st_nx   = RC_HALTED;
          pend_nx = 1'b0;
        end else begin
          pend_nx = want_stop;
        end
      end
      RC_HALTED: begin
        pend_nx = 1'b0;
        if (cmd_halt)      st_nx = RC_HALTED;
        else if (cmd_step) st_nx = RC_STEP;
        else if (cmd_run)  st_nx = RC_RUN;
      end
      RC_STEP: begin
        pend_nx = 1'b0;
        if (puc_brk || insn_boundary) st_nx = RC_HALTED;
      end
      default: begin
        st_nx   = RC_RUN;
        pend_nx = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RC_RUN;
      pend_q <= 1'b0;
    end else if (!en) begin
      st_q   <= RC_RUN;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      pend_q <= pend_nx;
    end
  end

  assign halted = (st_q == RC_HALTED);

  // R4: halting happens only at a boundary or through break-on-reset
  a_r4_halt_at_boundary: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $rose(halted) |-> $past(insn_boundary || puc_brk));

  // R6: a step from the stopped state releases the core
  a_r6_step_releases: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (halted && cmd_step && !cmd_halt) |=> !halted);

  // R5: stop wins over resume and step while stopped
  a_r5_halt_priority: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (halted && cmd_halt) |=> halted);
endmodule

// File: rtl/dbgrc_top.sv
module dbgrc_top
  import dbgrc_pkg::*;
#(
  parameter int   NUM_HWBRK      = 2,
  parameter int   SYNC_STAGES    = 2,
  parameter int   OPC_W          = 16,
  parameter logic [OPC_W-1:0] BRK_OPCODE = 16'h4343,
  parameter logic RSTBRK_DEFAULT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbg_enable,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 fetch_valid,
  input  logic [OPC_W-1:0]     fetch_opcode,
  input  logic [NUM_HWBRK-1:0] hwbrk_hit,
  input  logic                 puc_event,
  input  logic                 insn_boundary,
  output logic                 cpu_halt,
  output logic                 cpu_reset,
  output logic                 dbg_freeze
);
  logic en_s;
  logic cfg_swbrk_en, cfg_frz_en, cfg_rstbrk_en, cfg_cpu_rst;
  logic cmd_halt, cmd_run, cmd_step;
  logic swbrk_hit, brk_evt, puc_brk, halted;

  dbgrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(dbg_enable), .q_sync(en_s)
  );

  dbgrc_opdet #(.OPC_W(OPC_W), .BRK_OPCODE(BRK_OPCODE)) u_opdet (
    .fetch_valid(fetch_valid), .fetch_opcode(fetch_opcode),
    .detect_en(cfg_swbrk_en && en_s), .hit(swbrk_hit)
  );

  assign brk_evt = swbrk_hit || (|hwbrk_hit);
  assign puc_brk = puc_event && cfg_rstbrk_en;

  dbgrc_regs #(.NUM_HWBRK(NUM_HWBRK), .RSTBRK_DEFAULT(RSTBRK_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(en_s),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .swbrk_hit(swbrk_hit), .hwbrk_hit(hwbrk_hit), .puc_event(puc_event), .halted(halted),
    .cfg_swbrk_en(cfg_swbrk_en), .cfg_frz_en(cfg_frz_en),
    .cfg_rstbrk_en(cfg_rstbrk_en), .cfg_cpu_rst(cfg_cpu_rst),
    .cmd_halt(cmd_halt), .cmd_run(cmd_run), .cmd_step(cmd_step)
  );

  dbgrc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en_s),
    .cmd_halt(cmd_halt), .cmd_run(cmd_run), .cmd_step(cmd_step),
    .brk_evt(brk_evt), .puc_brk(puc_brk), .insn_boundary(insn_boundary),
    .halted(halted)
  );

  assign cpu_halt   = halted;
  assign cpu_reset  = cfg_cpu_rst;
  assign dbg_freeze = halted && cfg_frz_en;

  // R10: a power-up-clear is always recorded
  a_r10_puc_recorded: assert property (@(posedge clk) disable iff (!rst_n || !en_s)
    puc_event |=> u_regs.pnd_q[ST_PUC]);

  // R10: with break-on-reset set, a power-up-clear stops the core at once
  a_r10_puc_halts: assert property (@(posedge clk) disable iff (!rst_n || !en_s)
    (puc_event && cfg_rstbrk_en) |=> cpu_halt);

  // R12: freeze never shows while the core runs
  a_r12_freeze_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_freeze |-> cpu_halt);
endmodule

// File: tb/test_dbgrc_top.sv
module test_dbgrc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NHW = 2;
  localparam logic [15:0] BRK = 16'h4343;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_enable = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic fetch_valid = 1'b0;
  logic [15:0] fetch_opcode = '0;
  logic [NHW-1:0] hwbrk_hit = '0;
  logic puc_event = 1'b0;
  logic insn_boundary = 1'b0;
  logic cpu_halt, cpu_reset, dbg_freeze;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgrc_top i_dbgrc_top (
    .clk(clk), .rst_n(rst_n), .dbg_enable(dbg_enable),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fetch_valid(fetch_valid), .fetch_opcode(fetch_opcode), .hwbrk_hit(hwbrk_hit),
    .puc_event(puc_event), .insn_boundary(insn_boundary),
    .cpu_halt(cpu_halt), .cpu_reset(cpu_reset), .dbg_freeze(dbg_freeze)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string tag, input logic sel, input logic [7:0] exp);
    reg_sel = sel;
    #1;
    chk(tag, {8'h0, reg_rdata}, {8'h0, exp});
  endtask

  task automatic boundary();
    insn_boundary = 1'b1; tick(); insn_boundary = 1'b0;
  endtask

  // expected status word: pending bits with the stopped flag at bit 0
  function automatic logic [7:0] st(input logic [7:0] pnd, input logic h);
    return pnd | {7'b0, h};
  endfunction

  initial begin
    tick(3);
    rst_n = 1'b1; dbg_enable = 1'b1;
    tick(4);
    // R1 reset state
    chk("R1 halt after reset", {15'b0, cpu_halt}, 16'h0);
    chk("R1 reset out", {15'b0, cpu_reset}, 16'h0);
    rd("R1 status after reset", 1'b1, 8'h00);
    rd("R1 control after reset", 1'b0, 8'h00);

    // R2 sweep of all control values (no boundary, so no stop takes effect)
    for (int v = 0; v < 128; v++) begin
      wr(1'b0, 8'(v));
      rd("R2 control readback", 1'b0, 8'(v) & 8'h78);
      chk("R11 reset follows bit 6", {15'b0, cpu_reset}, {15'b0, v[6]});
    end

    // R1 disable returns everything to reset
    dbg_enable = 1'b0; tick(4);
    rd("R1 status while disabled", 1'b1, 8'h00);
    rd("R1 control while disabled", 1'b0, 8'h00);
    chk("R1 reset out while disabled", {15'b0, cpu_reset}, 16'h0);
    dbg_enable = 1'b1; tick(4);
    boundary();
    chk("R1 no stale stop after disable", {15'b0, cpu_halt}, 16'h0);

    // R4 stop waits for boundary
    wr(1'b0, 8'h01);
    tick(2);
    chk("R4 no stop without boundary", {15'b0, cpu_halt}, 16'h0);
    boundary();
    chk("R4 stop at boundary", {15'b0, cpu_halt}, 16'h1);
    rd("R3 status shows stopped", 1'b1, st(8'h00, 1'b1));
    chk("R12 no freeze with bit 4 clear", {15'b0, dbg_freeze}, 16'h0);
    wr(1'b0, 8'h10);
    chk("R12 freeze while stopped", {15'b0, dbg_freeze}, 16'h1);

    // R5 resume
    wr(1'b0, 8'h12);
    chk("R5 resume", {15'b0, cpu_halt}, 16'h0);
    chk("R12 freeze drops on resume", {15'b0, dbg_freeze}, 16'h0);

    // R4 stop written in the same cycle as the boundary
    insn_boundary = 1'b1; wr(1'b0, 8'h01); insn_boundary = 1'b0;
    chk("R4 stop with coincident boundary", {15'b0, cpu_halt}, 16'h1);
    // R5 stop beats resume and step
    wr(1'b0, 8'h07);
    chk("R5 stop wins over resume/step", {15'b0, cpu_halt}, 16'h1);
    tick();
    chk("R5 still stopped", {15'b0, cpu_halt}, 16'h1);

    // R6 single step
    wr(1'b0, 8'h04);
    chk("R6 step releases", {15'b0, cpu_halt}, 16'h0);
    tick(3);
    chk("R6 step waits for boundary", {15'b0, cpu_halt}, 16'h0);
    boundary();
    chk("R6 stopped after one instruction", {15'b0, cpu_halt}, 16'h1);

    // R7 opcode breakpoint disabled
    wr(1'b0, 8'h02);
    fetch_valid = 1'b1; fetch_opcode = BRK; tick(); fetch_valid = 1'b0;
    rd("R7 no pending when disabled", 1'b1, st(8'h00, 1'b0));
    boundary();
    chk("R7 no stop when disabled", {15'b0, cpu_halt}, 16'h0);
    // R7 near-miss opcodes with detection enabled
    wr(1'b0, 8'h08);
    for (int b = 0; b < 16; b++) begin
      fetch_valid = 1'b1; fetch_opcode = BRK ^ (16'h1 << b); tick(); fetch_valid = 1'b0;
      rd("R7 other opcode ignored", 1'b1, st(8'h00, 1'b0));
    end
    boundary();
    chk("R7 no stop on other opcodes", {15'b0, cpu_halt}, 16'h0);
    fetch_valid = 1'b1; fetch_opcode = BRK; tick(); fetch_valid = 1'b0;
    rd("R7 pending set", 1'b1, st(8'h08, 1'b0));
    boundary();
    chk("R7 stop at boundary", {15'b0, cpu_halt}, 16'h1);
    wr(1'b1, 8'h00);
    rd("R9 write 0 keeps pending", 1'b1, st(8'h08, 1'b1));
    wr(1'b1, 8'h08);
    rd("R9 write 1 clears pending", 1'b1, st(8'h00, 1'b1));
    wr(1'b0, 8'h0A);

    // R8 each hardware unit
    for (int i = 0; i < NHW; i++) begin
      hwbrk_hit = NHW'(1) << i; tick(); hwbrk_hit = '0;
      rd("R8 hw pending", 1'b1, st(8'h10 << i, 1'b0));
      boundary();
      chk("R8 hw stop", {15'b0, cpu_halt}, 16'h1);
      wr(1'b1, 8'h10 << i);
      wr(1'b0, 8'h0A);
      rd("R8 cleared and running", 1'b1, st(8'h00, 1'b0));
    end

    // R9 clear coinciding with a new event
    hwbrk_hit = 2'b01; tick(); hwbrk_hit = '0;
    hwbrk_hit = 2'b01; wr(1'b1, 8'h10); hwbrk_hit = '0;
    rd("R9 set beats clear", 1'b1, st(8'h10, 1'b0));
    wr(1'b1, 8'h10);
    boundary();
    wr(1'b0, 8'h02);
    rd("R9 cleared after resume", 1'b1, st(8'h00, 1'b0));

    // R10 power-up-clear
    puc_event = 1'b1; tick(); puc_event = 1'b0;
    rd("R10 puc recorded", 1'b1, st(8'h02, 1'b0));
    chk("R10 no stop without bit 5", {15'b0, cpu_halt}, 16'h0);
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h20);
    puc_event = 1'b1; tick(); puc_event = 1'b0;
    chk("R10 stop on puc", {15'b0, cpu_halt}, 16'h1);
    rd("R10 status after puc", 1'b1, st(8'h02, 1'b1));
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h02);

    // R11 core reset bit
    wr(1'b0, 8'h40);
    chk("R11 reset asserted", {15'b0, cpu_reset}, 16'h1);
    rd("R11 rise sets pending", 1'b1, st(8'h02, 1'b0));
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h40);
    rd("R11 rewrite keeps pending clear", 1'b1, st(8'h00, 1'b0));
    chk("R11 reset still asserted", {15'b0, cpu_reset}, 16'h1);
    wr(1'b0, 8'h00);
    chk("R11 reset released", {15'b0, cpu_reset}, 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule